// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block is the master side of an external memory and I/O bus in which the low address byte and the data byte share one set of eight pins. An internal requester starts one transfer at a time. A transfer carries a 16-bit address, a write byte, a read/write flag and a select between data memory and program memory. The block then steps through an address phase and a data phase. In the address phase it drives the low address byte and pulses the address strobe. In the data phase it either floats the shared bus or drives the write byte while the data strobe is low.

The upper address byte is presented on a separate output group, which is enabled by a configuration input. A configuration input can also lengthen the data phase by a fixed number of clocks. An active-low wait input is sampled at the end of the data-setup part of the cycle and again at the end of every wait state. Each low sample adds one wait state. At the end of the transfer the block raises a one-clock done pulse. On a read, the captured byte is presented in the same clock.

Top module: `xbus_ctrl`

## Requirements
- R1: While idle, and after reset, `as_n`=1, `ds_n`=1, `bus_oe`=0, `rw_n`=1, `dm_n`=1, `rsp_done`=0 and `req_ready`=1. After reset `rsp_rdata`=0 and `hi_addr_out`=0.
- R2: A transfer is accepted on a clock edge where `req_start`=1 and `req_ready`=1. Counting the clock after that edge as clock 1, `bus_oe`=1 and `bus_out` is the low address byte in clocks 1 to 3. `as_n` is low in clock 2 only.
- R3: In every clock from 1 to the done clock, `rw_n` is the inverse of the latched write flag (0 = write) and `dm_n` is the inverse of the latched data-memory flag (0 = data memory). Request inputs that change after acceptance have no effect.
- R4: On a read, `bus_oe`=0 from clock 4 to the done clock. `bus_in` is captured at the end of the last clock in which `ds_n` is low, and the captured value is shown on `rsp_rdata` from the done clock until the next read captures.
- R5: On a write, `bus_oe`=1 and `bus_out` is the write byte from clock 4 up to and including the done clock, which is one clock after `ds_n` rises.
- R6: `ds_n` is low in one contiguous run that starts in clock 5 and lasts 2 + X + W clocks. X is the extension length and W is the number of wait states. `ds_n` is high in the done clock.
- R7: `wait_n` is sampled only at the end of the last clock of the data-setup part (clock 5 + X) and at the end of each wait state. Each sample of 0 inserts one more wait clock. Values of `wait_n` in any other clock have no effect.
- R8: When `cfg_ext_timing`=1 at acceptance, X = EXT_CLKS (default 2). Otherwise X = 0. Changes to `cfg_ext_timing` after acceptance have no effect.
- R9: `rsp_done` is a single-clock pulse in clock 7 + X + W. `req_ready`=0 from clock 1 through the done clock, and `req_start` during that time is ignored.
- R10: `hi_addr_oe` follows `cfg_hi_addr_en`. `hi_addr_out` carries bits 15..8 of the most recently accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start a transfer (taken when ready) |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_mem | input | 1 | 1 = data memory, 0 = program memory |
| cfg_ext_timing | input | 1 | Lengthen the data phase by EXT_CLKS clocks |
| cfg_hi_addr_en | input | 1 | Drive the upper address byte |
| wait_n | input | 1 | Active-low wait request |
| bus_in | input | 8 | Shared bus, pin input side |
| req_ready | output | 1 | Idle, able to accept a transfer |
| rsp_done | output | 1 | One-clock end-of-transfer pulse |
| rsp_rdata | output | 8 | Captured read byte |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | 1 = read, 0 = write |
| dm_n | output | 1 | Data-memory select, active low |
| bus_out | output | 8 | Shared bus, pin output side |
| bus_oe | output | 1 | Shared bus output enable |
| hi_addr_out | output | 8 | Upper address byte |
| hi_addr_oe | output | 1 | Upper address output enable |

## Verification
The assertions assume that `wait_n` and `bus_in` are synchronous to the clock and hold defined values at every sampling edge. They also assume that reset is applied synchronously before the first transfer. They never assume that `req_start` is withheld while a transfer runs, because such a start must be dropped by the block itself. The stimulus changes every input only at the falling clock edge. It drives `bus_in` with the inverse of the expected byte outside the strobe window. It also pulses `wait_n` low in clocks where it must be ignored, and alters the request fields and `req_start` while the block is busy.

// File: rtl/xbus_pkg.sv
// Shared types for the multiplexed external bus controller.
// Each state lasts one clock. The T1/T2/T3 phases are split into clock-level steps.
package xbus_pkg;
    typedef enum logic [3:0] {
        XS_IDLE, // strobes high, bus released
        XS_T1A,  // address driven, address strobe still high (setup)
        XS_T1B,  // address strobe low
        XS_T2A,  // address strobe high again, address still held
        XS_T2B,  // bus turned around (float or write byte), data strobe high
        XS_T2C,  // data strobe low, end of the basic data setup
        XS_T2X,  // extension clocks of the data setup
        XS_TW,   // wait state
        XS_T3A,  // last clock with data strobe low, read capture at its end
        XS_T3B   // data strobe high, done pulse, write data still held
    } xbus_state_e;
endpackage

// File: rtl/xbus_seq.sv
// Cycle sequencer: walks the bus states and decodes both strobes.
// Assumes wait_n is synchronous to clk. The extension setting is latched at acceptance.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int EXT_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept_i,
    input  logic        ext_i,
    input  logic        wait_n_i,
    output xbus_state_e state_o,
    output logic        as_n_o,
    output logic        ds_n_o
);
    localparam bit EXT_ON = (EXT_CLKS > 0);

    xbus_state_e state_q, state_d;
    logic        ext_q;
    logic        ext_last;

    // Latch the extension setting when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)        ext_q <= 1'b0;
        else if (accept_i) ext_q <= ext_i;
    end

    generate
        if (EXT_ON) begin : g_ext
            localparam int CNT_W = (EXT_CLKS > 1) ? $clog2(EXT_CLKS) : 1;
            logic [CNT_W-1:0] cnt_q;
            // Count down the extension clocks inside T2.
            always_ff @(posedge clk) begin
                if (!rst_n)                              cnt_q <= '0;
                else if (state_q == XS_T2C)              cnt_q <= CNT_W'(EXT_CLKS - 1);
                else if (state_q == XS_T2X && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
            end
            assign ext_last = (cnt_q == '0);
        end else begin : g_noext
            assign ext_last = 1'b1;
        end
    endgenerate

    // Next-state selection, including the wait decision at the end of T2 and each TW.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (accept_i) state_d = XS_T1A;
            XS_T1A:  state_d = XS_T1B;
            XS_T1B:  state_d = XS_T2A;
            XS_T2A:  state_d = XS_T2B;
            XS_T2B:  state_d = XS_T2C;
            XS_T2C: begin
                if (EXT_ON && ext_q) state_d = XS_T2X;
                else                 state_d = wait_n_i ? XS_T3A : XS_TW;
            end
            XS_T2X:  if (ext_last) state_d = wait_n_i ? XS_T3A : XS_TW;
            XS_TW:   state_d = wait_n_i ? XS_T3A : XS_TW;
            XS_T3A:  state_d = XS_T3B;
            XS_T3B:  state_d = XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Strobe decode from the current state.
    always_comb begin
        as_n_o = (state_q != XS_T1B);
        ds_n_o = !(state_q inside {XS_T2C, XS_T2X, XS_TW, XS_T3A});
    end

    assign state_o = state_q;
endmodule

// File: rtl/xbus_dpath.sv
// Datapath: latches the request, steers the shared bus and captures read data.
// Assumes ADDR_W > DATA_W. The upper address bits go to the separate port.
module xbus_dpath
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept_i,
    input  xbus_state_e              state_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic                     write_i,
    input  logic                     dmem_i,
    input  logic                     hi_en_i,
    input  logic [DATA_W-1:0]        bus_in_i,
    output logic [DATA_W-1:0]        bus_out_o,
    output logic                     bus_oe_o,
    output logic                     rw_n_o,
    output logic                     dm_n_o,
    output logic [DATA_W-1:0]        rdata_o,
    output logic [ADDR_W-DATA_W-1:0] hi_out_o,
    output logic                     hi_oe_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_q;
    logic              dm_q;
    logic              active;
    logic              addr_phase;

    // Request latch, loaded once per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            dm_q    <= 1'b0;
        end else if (accept_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            wr_q    <= write_i;
            dm_q    <= dmem_i;
        end
    end

    // Read capture on the edge where the data strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n)                               rdata_q <= '0;
        else if (state_i == XS_T3A && !wr_q)      rdata_q <= bus_in_i;
    end

    // Bus steering and the cycle-type outputs.
    always_comb begin
        active     = (state_i != XS_IDLE);
        addr_phase = state_i inside {XS_T1A, XS_T1B, XS_T2A};
        bus_oe_o   = addr_phase || (active && wr_q);
        bus_out_o  = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
        rw_n_o     = active ? !wr_q : 1'b1;
        dm_n_o     = active ? !dm_q : 1'b1;
    end

    assign rdata_o  = rdata_q;
    assign hi_out_o = addr_q[ADDR_W-1:DATA_W];
    assign hi_oe_o  = hi_en_i;
endmodule

// File: rtl/xbus_ctrl.sv
// Top of the multiplexed external bus controller.
// Handles one transfer at a time. A start is taken only while idle.
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int EXT_CLKS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_start,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_write,
    input  logic                     req_data_mem,
    input  logic                     cfg_ext_timing,
    input  logic                     cfg_hi_addr_en,
    input  logic                     wait_n,
    input  logic [DATA_W-1:0]        bus_in,
    output logic                     req_ready,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     as_n,
    output logic                     ds_n,
    output logic                     rw_n,
    output logic                     dm_n,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_addr_out,
    output logic                     hi_addr_oe
);
    xbus_state_e state;
    logic        accept;

    // Acceptance and the request-side status.
    always_comb begin
        req_ready = (state == XS_IDLE);
        rsp_done  = (state == XS_T3B);
        accept    = req_start && req_ready;
    end

    xbus_seq #(.EXT_CLKS(EXT_CLKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .ext_i    (cfg_ext_timing),
        .wait_n_i (wait_n),
        .state_o  (state),
        .as_n_o   (as_n),
        .ds_n_o   (ds_n)
    );

    xbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .state_i   (state),
        .addr_i    (req_addr),
        .wdata_i   (req_wdata),
        .write_i   (req_write),
        .dmem_i    (req_data_mem),
        .hi_en_i   (cfg_hi_addr_en),
        .bus_in_i  (bus_in),
        .bus_out_o (bus_out),
        .bus_oe_o  (bus_oe),
        .rw_n_o    (rw_n),
        .dm_n_o    (dm_n),
        .rdata_o   (rsp_rdata),
        .hi_out_o  (hi_addr_out),
        .hi_oe_o   (hi_addr_oe)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
// Protocol checker for xbus_ctrl. Observes the top-level ports only.
module xbus_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              as_n,
    input logic              ds_n,
    input logic              rw_n,
    input logic              dm_n,
    input logic              bus_oe
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (as_n && ds_n && !bus_oe && rw_n && dm_n));

    p_as_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |=> as_n);

    p_as_drives_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> (bus_oe && ds_n));

    p_type_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready) && !$past(rsp_done)) |-> ($stable(rw_n) && $stable(dm_n)));

    p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rw_n) |-> !bus_oe);

    p_rdata_only_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> rsp_done);

    p_write_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !rw_n) |-> bus_oe);

    p_ds_rise_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> rsp_done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DATA_W(DATA_W)) u_xbus_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .rw_n      (rw_n),
    .dm_n      (dm_n),
    .bus_oe    (bus_oe)
);

// File: tb/tb_xbus_ctrl.sv
// Bench for xbus_ctrl. A per-clock behavioural reference, derived from the
// requirements, is compared with the ports at every falling edge.
module tb_xbus_ctrl;
    localparam int EXT = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_start, req_write, req_data_mem, cfg_ext_timing, cfg_hi_addr_en, wait_n;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata, bus_in;
    logic        req_ready, rsp_done, as_n, ds_n, rw_n, dm_n, bus_oe, hi_addr_oe;
    logic [7:0]  rsp_rdata, bus_out, hi_addr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] last_rd = 8'h00;
    logic [7:0] last_hi = 8'h00;

    always #2 clk = ~clk;

    xbus_ctrl #(.ADDR_W(16), .DATA_W(8), .EXT_CLKS(EXT)) dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_data_mem(req_data_mem),
        .cfg_ext_timing(cfg_ext_timing), .cfg_hi_addr_en(cfg_hi_addr_en),
        .wait_n(wait_n), .bus_in(bus_in), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dm_n(dm_n),
        .bus_out(bus_out), .bus_oe(bus_oe), .hi_addr_out(hi_addr_out), .hi_addr_oe(hi_addr_oe)
    );

    task automatic chk(input string tag, input string what, input int c, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s clock %0d: actual %0h expected %0h", tag, what, c, act, exp);
        end
    endtask

    // Idle expectations (R1) plus held outputs (R4, R10).
    task automatic chk_idle(input bit hi_en);
        chk("R1", "as_n", 0, as_n, 1);
        chk("R1", "ds_n", 0, ds_n, 1);
        chk("R1", "bus_oe", 0, bus_oe, 0);
        chk("R1", "rw_n", 0, rw_n, 1);
        chk("R1", "dm_n", 0, dm_n, 1);
        chk("R1", "rsp_done", 0, rsp_done, 0);
        chk("R1", "req_ready", 0, req_ready, 1);
        chk("R4", "rsp_rdata held", 0, rsp_rdata, last_rd);
        chk("R10", "hi_addr_out", 0, hi_addr_out, last_hi);
        chk("R10", "hi_addr_oe", 0, hi_addr_oe, hi_en);
    endtask

    // One transfer: noise alters inputs that must be ignored.
    task automatic run_txn(input logic [15:0] a, input logic [7:0] wd, input logic [7:0] rd,
                           input bit wr, input bit dm, input bit ext, input bit hi,
                           input int w, input bit noise);
        int x;
        int n;
        string dtag;
        x = ext ? EXT : 0;
        n = 7 + x + w;
        dtag = ext ? "R8" : ((w > 0) ? "R7" : "R6");
        @(negedge clk);
        req_addr = a; req_wdata = wd; req_write = wr; req_data_mem = dm;
        cfg_ext_timing = ext; cfg_hi_addr_en = hi; req_start = 1'b1;
        bus_in = ~rd; wait_n = 1'b1;
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            if (noise) begin
                req_addr = ~a; req_wdata = ~wd; req_write = ~wr; req_data_mem = ~dm;
                cfg_ext_timing = ~ext;
                if (c == n) req_start = 1'b0;
            end else begin
                req_start = 1'b0;
            end
            chk("R2", "as_n", c, as_n, (c == 2) ? 0 : 1);
            chk(dtag, "ds_n", c, ds_n, (c >= 5 && c <= n - 1) ? 0 : 1);
            chk("R3", "rw_n", c, rw_n, wr ? 0 : 1);
            chk("R3", "dm_n", c, dm_n, dm ? 0 : 1);
            chk("R9", "rsp_done", c, rsp_done, (c == n) ? 1 : 0);
            chk("R9", "req_ready", c, req_ready, 0);
            chk("R10", "hi_addr_out", c, hi_addr_out, a[15:8]);
            if (c <= 3) begin
                chk("R2", "bus_oe", c, bus_oe, 1);
                chk("R2", "bus_out addr", c, bus_out, a[7:0]);
            end else if (wr) begin
                chk("R5", "bus_oe", c, bus_oe, 1);
                chk("R5", "bus_out data", c, bus_out, wd);
            end else begin
                chk("R4", "bus_oe", c, bus_oe, 0);
            end
            if (c == n && !wr) chk("R4", "rsp_rdata", c, rsp_rdata, rd);
            // Inputs that the end of this clock may sample.
            wait_n = !((c >= 5 + x && c <= 4 + x + w) || (noise && c <= 4));
            bus_in = (c >= 5 && c <= n - 1) ? rd : ~rd;
        end
        wait_n = 1'b1;
        if (!wr) last_rd = rd;
        last_hi = a[15:8];
        cfg_hi_addr_en = hi;
        @(negedge clk);
        chk_idle(hi);
    endtask

    initial begin
        rst_n = 1'b0; req_start = 1'b0; req_addr = 16'h0; req_wdata = 8'h0;
        req_write = 1'b0; req_data_mem = 1'b0; cfg_ext_timing = 1'b0;
        cfg_hi_addr_en = 1'b0; wait_n = 1'b1; bus_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_idle(1'b0);
        run_txn(16'h12A5, 8'h00, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0);
        run_txn(16'hBE07, 8'h5A, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run_txn(16'h4411, 8'h00, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
        run_txn(16'h8001, 8'hA9, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3, 1'b0);
        run_txn(16'h0F0F, 8'h00, 8'h96, 1'b0, 1'b1, 1'b0, 1'b1, 1, 1'b1);
        run_txn(16'h7E81, 8'h18, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 2, 1'b1);
        run_txn(16'hFFFF, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 5, 1'b0);
        run_txn(16'h0000, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0);
        run_txn(16'h2B6D, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 4, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule